// File: doc/BRIEF.md
# Processor Sleep State Controller

This block decides when a small processor core goes to sleep, which clock domains stay alive while it sleeps, and how it comes back. The core raises a one-cycle strobe when it executes its sleep instruction. The block enters sleep only if the software-written sleep-enable bit is set on that cycle. On entry it latches a 3-bit mode select. That mode sets two things: which of the CPU, flash, I/O and asynchronous-timer clock domains keep their enables, and which classes of interrupt request can end the sleep.

An eligible interrupt starts a wake-up. The core stays halted for a per-mode oscillator start-up delay plus four further cycles. After that the block pulses an interrupt-wake event, so the handler runs before execution continues. A reset request seen while asleep, or while starting up, ends the sleep at once and pulses a reset-wake event instead. If an ADC is enabled, entering one of the two light modes issues a single-cycle conversion start.

Top module: `slp_ctrl`

## Requirements
- R1: The sleep strobe puts the block to sleep only when `sleep_en` is 1 in the same cycle. Sleep is shown as `core_halt` high from the next cycle. With `sleep_en` 0, or while not running, the strobe has no effect.
- R2: `mode_sel` is latched at entry and encoded as follows: 000 Idle, 001 ADC noise reduction, 010 Power-down, 011 Power-save, 110 Standby, 111 Extended Standby. The reserved values 100 and 101 behave exactly as Idle.
- R3: `clk_cpu_en` and `clk_flash_en` are 0 whenever the block is asleep or starting up, in every mode. Idle keeps `clk_io_en` and `clk_async_en` at 1.
- R4: While running, all four clock enables are 1. While asleep or starting up, `clk_io_en` is 1 only in Idle. `clk_async_en` is 1 only in Idle, ADC noise reduction, Power-save and Extended Standby.
- R5: On an interrupt wake seen at a clock edge, `core_halt` stays 1 for start-up delay + 4 cycles after that edge. It then falls, and `wake_irq` is 1 for exactly the first cycle with `core_halt` 0.
- R6: The start-up delay is 0 for Idle (and the reserved codes) and for ADC noise reduction. It is SLOW_DLY for Power-down and Power-save, and FAST_DLY for Standby and Extended Standby. SLOW_DLY must exceed FAST_DLY.
- R7: `ext_rst` high while asleep or starting up drops `core_halt` on the next cycle and pulses `wake_rst` for one cycle, with no `wake_irq`. `ext_rst` has no effect while running.
- R8: When `adc_en` is 1 at entry into Idle (or a reserved code) or ADC noise reduction, `adc_start` is 1 for exactly one cycle, namely the first sleeping cycle. Entry into any other mode gives no pulse.
- R9: Each `irq_ext_lo` line wakes the core in every mode. An `irq_ext_hi[i]` line wakes it in Idle. In every other mode it wakes it only if `ext_hi_level[i]` is 1; otherwise that line is ignored.
- R10: `trx_wake` wakes the core in any mode, but only while `trx_osc_en` is 1.
- R11: A wake request that arrives while start-up is counting neither restarts nor shortens the count.
- R12: `irq_sync` lines wake the core only in Idle and ADC noise reduction. `irq_async` wakes it only in the modes where `clk_async_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_en | input | 1 | Sleep-enable bit from software |
| mode_sel | input | 3 | Sleep mode select |
| sleep_strobe | input | 1 | One-cycle pulse from the sleep instruction |
| adc_en | input | 1 | ADC enabled |
| ext_rst | input | 1 | Reset request that ends sleep |
| irq_sync | input | N_SYNC | Enabled peripheral interrupts needing the I/O clock |
| irq_async | input | 1 | Enabled asynchronous-timer interrupt |
| irq_ext_lo | input | N_EXT_LO | Enabled lower external interrupt lines |
| irq_ext_hi | input | N_EXT_HI | Enabled upper external interrupt lines |
| ext_hi_level | input | N_EXT_HI | 1 = matching upper line configured level-sensitive |
| trx_wake | input | 1 | Transceiver / symbol-counter wake request |
| trx_osc_en | input | 1 | Transceiver oscillator running |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_async_en | output | 1 | Asynchronous timer clock enable |
| core_halt | output | 1 | Core held halted |
| adc_start | output | 1 | ADC conversion start pulse |
| wake_irq | output | 1 | Pulse: resume through interrupt handler |
| wake_rst | output | 1 | Pulse: restart from reset vector |

## Verification
The bench visits every mode code, including the two reserved ones. It measures the exact halt length after a wake for each delay class. A counter off by one, or one that ignores the extra four cycles, would release the core a cycle early or late. It sends edge-configured upper external lines, transceiver wakes with the oscillator off, and peripheral interrupts into deep modes, all of which must be ignored. A filter that got this wrong would wake the core out of deep sleep. It also retriggers wake during start-up and asserts reset both asleep and mid start-up. These catch a counter that reloads and lengthens the halt, and a reset that loses priority to a pending interrupt wake.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [2:0] {
      M_IDLE  = 3'b000,
      M_ADCNR = 3'b001,
      M_PDOWN = 3'b010,
      M_PSAVE = 3'b011,
      M_RSV4  = 3'b100,
      M_RSV5  = 3'b101,
      M_STBY  = 3'b110,
      M_XSTBY = 3'b111
   } slp_mode_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_START = 2'd2
   } slp_state_e;

   typedef enum logic [1:0] {
      DLY_NONE = 2'd0,
      DLY_SLOW = 2'd1,
      DLY_FAST = 2'd2
   } slp_dly_e;

   typedef struct packed {
      logic     io_on;
      logic     async_on;
      logic     sync_wake;
      logic     idle_like;
      slp_dly_e dly;
   } slp_policy_t;

   function automatic logic mode_starts_adc(input logic [2:0] m);
      return (m == M_IDLE) || (m == M_ADCNR) || (m == M_RSV4) || (m == M_RSV5);
   endfunction

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
   import slp_pkg::*;
(
   input  slp_mode_e   mode,
   output slp_policy_t pol
);

   always_comb begin
      pol = '{io_on: 1'b0, async_on: 1'b0, sync_wake: 1'b0,
              idle_like: 1'b0, dly: DLY_NONE};
      unique case (mode)
         M_IDLE, M_RSV4, M_RSV5: begin
            pol.io_on     = 1'b1;
            pol.async_on  = 1'b1;
            pol.sync_wake = 1'b1;
            pol.idle_like = 1'b1;
         end
         M_ADCNR: begin
            pol.async_on  = 1'b1;
            pol.sync_wake = 1'b1;
         end
         M_PDOWN: pol.dly = DLY_SLOW;
         M_PSAVE: begin
            pol.async_on = 1'b1;
            pol.dly      = DLY_SLOW;
         end
         M_STBY:  pol.dly = DLY_FAST;
         M_XSTBY: begin
            pol.async_on = 1'b1;
            pol.dly      = DLY_FAST;
         end
         default: pol.dly = DLY_NONE;
      endcase
   end

endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter #(
   parameter int N_SYNC   = 4,
   parameter int N_EXT_LO = 4,
   parameter int N_EXT_HI = 4
) (
   input  logic                sync_ok,
   input  logic                async_ok,
   input  logic                idle_like,
   input  logic [N_SYNC-1:0]   irq_sync,
   input  logic                irq_async,
   input  logic [N_EXT_LO-1:0] irq_ext_lo,
   input  logic [N_EXT_HI-1:0] irq_ext_hi,
   input  logic [N_EXT_HI-1:0] ext_hi_level,
   input  logic                trx_wake,
   input  logic                trx_osc_en,
   output logic                wake_req
);

   logic [N_EXT_HI-1:0] hi_ok;

   for (genvar i = 0; i < N_EXT_HI; i++) begin : g_hi
      assign hi_ok[i] = irq_ext_hi[i] & (idle_like | ext_hi_level[i]);
   end

   assign wake_req = (sync_ok & (|irq_sync))
                   | (async_ok & irq_async)
                   | (|irq_ext_lo)
                   | (|hi_ok)
                   | (trx_wake & trx_osc_en);

endmodule

// File: rtl/slp_startup_timer.sv
module slp_startup_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
   import slp_pkg::*;
#(
   parameter int N_SYNC   = 4,
   parameter int N_EXT_LO = 4,
   parameter int N_EXT_HI = 4,
   parameter int SLOW_DLY = 16,
   parameter int FAST_DLY = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_en,
   input  logic [2:0]          mode_sel,
   input  logic                sleep_strobe,
   input  logic                adc_en,
   input  logic                ext_rst,
   input  logic [N_SYNC-1:0]   irq_sync,
   input  logic                irq_async,
   input  logic [N_EXT_LO-1:0] irq_ext_lo,
   input  logic [N_EXT_HI-1:0] irq_ext_hi,
   input  logic [N_EXT_HI-1:0] ext_hi_level,
   input  logic                trx_wake,
   input  logic                trx_osc_en,
   output logic                clk_cpu_en,
   output logic                clk_flash_en,
   output logic                clk_io_en,
   output logic                clk_async_en,
   output logic                core_halt,
   output logic                adc_start,
   output logic                wake_irq,
   output logic                wake_rst
);

   localparam int HOLD_EXTRA = 4;
   localparam int CNT_W      = $clog2(SLOW_DLY + HOLD_EXTRA);
   localparam logic [CNT_W-1:0] LD_NONE = CNT_W'(HOLD_EXTRA - 1);
   localparam logic [CNT_W-1:0] LD_SLOW = CNT_W'(SLOW_DLY + HOLD_EXTRA - 1);
   localparam logic [CNT_W-1:0] LD_FAST = CNT_W'(FAST_DLY + HOLD_EXTRA - 1);

   if (SLOW_DLY <= FAST_DLY) begin : g_bad_dly
      $error("slp_ctrl: SLOW_DLY must be larger than FAST_DLY");
   end
   if (FAST_DLY < 0) begin : g_bad_fast
      $error("slp_ctrl: FAST_DLY must not be negative");
   end
   if (N_SYNC < 1 || N_EXT_LO < 1 || N_EXT_HI < 1) begin : g_bad_width
      $error("slp_ctrl: interrupt vectors need at least one line");
   end

   slp_state_e       state_q;
   slp_mode_e        mode_q;
   slp_policy_t      pol;
   logic             adc_q, wirq_q, wrst_q;
   logic             wake_req, tmr_zero, tmr_load;
   logic [CNT_W-1:0] tmr_val;

   slp_mode_decode i_dec (
      .mode (mode_q),
      .pol  (pol)
   );

   slp_wake_filter #(
      .N_SYNC   (N_SYNC),
      .N_EXT_LO (N_EXT_LO),
      .N_EXT_HI (N_EXT_HI)
   ) i_filt (
      .sync_ok      (pol.sync_wake),
      .async_ok     (pol.async_on),
      .idle_like    (pol.idle_like),
      .irq_sync     (irq_sync),
      .irq_async    (irq_async),
      .irq_ext_lo   (irq_ext_lo),
      .irq_ext_hi   (irq_ext_hi),
      .ext_hi_level (ext_hi_level),
      .trx_wake     (trx_wake),
      .trx_osc_en   (trx_osc_en),
      .wake_req     (wake_req)
   );

   always_comb begin
      unique case (pol.dly)
         DLY_SLOW: tmr_val = LD_SLOW;
         DLY_FAST: tmr_val = LD_FAST;
         default:  tmr_val = LD_NONE;
      endcase
   end

   assign tmr_load = (state_q == ST_SLEEP) && !ext_rst && wake_req;

   slp_startup_timer #(.CNT_W(CNT_W)) i_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         mode_q  <= M_IDLE;
         adc_q   <= 1'b0;
         wirq_q  <= 1'b0;
         wrst_q  <= 1'b0;
      end else begin
         adc_q  <= 1'b0;
         wirq_q <= 1'b0;
         wrst_q <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (sleep_strobe && sleep_en) begin
                  state_q <= ST_SLEEP;
                  mode_q  <= slp_mode_e'(mode_sel);
                  adc_q   <= adc_en && mode_starts_adc(mode_sel);
               end
            end
            ST_SLEEP: begin
               if (ext_rst) begin
                  state_q <= ST_RUN;
                  wrst_q  <= 1'b1;
               end else if (wake_req) begin
                  state_q <= ST_START;
               end
            end
            ST_START: begin
               if (ext_rst) begin
                  state_q <= ST_RUN;
                  wrst_q  <= 1'b1;
               end else if (tmr_zero) begin
                  state_q <= ST_RUN;
                  wirq_q  <= 1'b1;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   logic running;
   assign running      = (state_q == ST_RUN);
   assign core_halt    = !running;
   assign clk_cpu_en   = running;
   assign clk_flash_en = running;
   assign clk_io_en    = running | pol.io_on;
   assign clk_async_en = running | pol.async_on;
   assign adc_start    = adc_q;
   assign wake_irq     = wirq_q;
   assign wake_rst     = wrst_q;

endmodule

// File: rtl/slp_ctrl_checker.sv
module slp_ctrl_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_en,
   input logic       sleep_strobe,
   input logic       ext_rst,
   input logic       clk_cpu_en,
   input logic       clk_flash_en,
   input logic       clk_io_en,
   input logic       core_halt,
   input logic       adc_start,
   input logic       wake_irq,
   input logic       wake_rst
);

   assert_no_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && sleep_strobe && !sleep_en) |=> !core_halt);

   assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && sleep_strobe && sleep_en) |=> core_halt);

   assert_core_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_halt |-> (!clk_cpu_en && !clk_flash_en));

   assert_io_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_io_en |-> core_halt);

   assert_irq_wake_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> (!core_halt && $past(core_halt)));

   assert_halt_end_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_halt) |-> (wake_irq || wake_rst));

   assert_rst_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_halt && ext_rst) |=> (!core_halt && wake_rst && !wake_irq));

   assert_adc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

   assert_adc_when_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> core_halt);

endmodule

bind slp_ctrl slp_ctrl_checker i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sleep_en     (sleep_en),
   .sleep_strobe (sleep_strobe),
   .ext_rst      (ext_rst),
   .clk_cpu_en   (clk_cpu_en),
   .clk_flash_en (clk_flash_en),
   .clk_io_en    (clk_io_en),
   .core_halt    (core_halt),
   .adc_start    (adc_start),
   .wake_irq     (wake_irq),
   .wake_rst     (wake_rst)
);

// File: tb/test_slp_ctrl.sv
`timescale 1ns/1ps
module test_slp_ctrl;

   localparam int NS = 4, NL = 4, NH = 4;
   localparam int SLOW = 16, FAST = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_en = 0, sleep_strobe = 0, adc_en = 0, ext_rst = 0;
   logic [2:0] mode_sel = 0;
   logic [NS-1:0] irq_sync = 0;
   logic irq_async = 0;
   logic [NL-1:0] irq_ext_lo = 0;
   logic [NH-1:0] irq_ext_hi = 0, ext_hi_level = 0;
   logic trx_wake = 0, trx_osc_en = 0;
   logic clk_cpu_en, clk_flash_en, clk_io_en, clk_async_en;
   logic core_halt, adc_start, wake_irq, wake_rst;

   always #4 clk = ~clk;

   slp_ctrl #(.N_SYNC(NS), .N_EXT_LO(NL), .N_EXT_HI(NH),
              .SLOW_DLY(SLOW), .FAST_DLY(FAST)) i_slp_ctrl (.*);

   int checks = 0, fails = 0;
   string cur_req = "R4";
   bit done = 0;

   // reference model state: 0 run, 1 asleep, 2 starting up
   int m_state, m_mode, m_left;
   bit m_adc, m_wi, m_wr;

   function automatic int dly_of(int m);
      if (m == 2 || m == 3) return SLOW;
      if (m == 6 || m == 7) return FAST;
      return 0;
   endfunction

   function automatic bit idle_mode(int m);
      return (m == 0 || m == 4 || m == 5);
   endfunction

   function automatic bit async_mode(int m);
      return idle_mode(m) || m == 1 || m == 3 || m == 7;
   endfunction

   function automatic bit can_wake(int m);
      bit w = 0;
      if ((idle_mode(m) || m == 1) && irq_sync != 0) w = 1;
      if (async_mode(m) && irq_async) w = 1;
      if (irq_ext_lo != 0) w = 1;
      for (int i = 0; i < NH; i++)
         if (irq_ext_hi[i] && (idle_mode(m) || ext_hi_level[i])) w = 1;
      if (trx_wake && trx_osc_en) w = 1;
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_mode = 0; m_left = 0;
         m_adc = 0; m_wi = 0; m_wr = 0;
      end else begin
         m_adc = 0; m_wi = 0; m_wr = 0;
         if (m_state == 0) begin
            if (sleep_strobe && sleep_en) begin
               m_state = 1;
               m_mode  = int'(mode_sel);
               m_adc   = adc_en && (idle_mode(m_mode) || m_mode == 1);
            end
         end else if (ext_rst) begin
            m_state = 0;
            m_wr    = 1;
         end else if (m_state == 1) begin
            if (can_wake(m_mode)) begin
               m_state = 2;
               m_left  = dly_of(m_mode) + 4;
            end
         end else begin
            m_left--;
            if (m_left == 0) begin
               m_state = 0;
               m_wi    = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      logic [7:0] act, exp;
      bit run;
      if (!done) begin
         run = (m_state == 0);
         exp = {run, run, run || idle_mode(m_mode), run || async_mode(m_mode),
                !run, m_adc, m_wi, m_wr};
         act = {clk_cpu_en, clk_flash_en, clk_io_en, clk_async_en,
                core_halt, adc_start, wake_irq, wake_rst};
         checks++;
         if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t {cpu,flash,io,async,halt,adc,wirq,wrst} actual %b expected %b",
                     cur_req, $time, act, exp);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic enter(int m);
      mode_sel = 3'(m); sleep_en = 1; sleep_strobe = 1;
      tick(1);
      sleep_strobe = 0;
      tick(1);
   endtask

   task automatic pulse_lo();
      irq_ext_lo[0] = 1; tick(1); irq_ext_lo[0] = 0;
   endtask

   task automatic pulse_rst();
      ext_rst = 1; tick(1); ext_rst = 0;
   endtask

   task automatic finish_up();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R5 watchdog: actual hung, expected completion");
         finish_up();
      end
   end

   initial begin
      // R4: reset state, all domains on
      cur_req = "R4";
      tick(3);
      rst_n = 1;
      tick(3);

      // R1: strobe without enable is ignored, then a real entry
      cur_req = "R1";
      mode_sel = 3'b010; sleep_en = 0; sleep_strobe = 1;
      tick(1); sleep_strobe = 0; tick(4);
      enter(0); tick(2); pulse_lo(); tick(8);

      // R2 / R6: every code incl. reserved, each delay class
      for (int m = 0; m < 8; m++) begin
         cur_req = "R2";
         enter(m); tick(3);
         cur_req = "R6";
         pulse_lo(); tick(SLOW + 8);
      end

      // R3: Idle domains
      cur_req = "R3";
      enter(0); tick(3); pulse_lo(); tick(8);

      // R8: ADC start pulse on light-mode entry only
      cur_req = "R8";
      adc_en = 1;
      enter(0); tick(2); pulse_lo(); tick(8);
      enter(1); tick(2); pulse_lo(); tick(8);
      enter(5); tick(2); pulse_lo(); tick(8);
      enter(2); tick(2); pulse_lo(); tick(SLOW + 8);
      adc_en = 0;

      // R9: upper external lines, edge config ignored in deep modes
      cur_req = "R9";
      enter(2);
      irq_ext_hi = 4'b1111; tick(1); irq_ext_hi = 0; tick(5);
      ext_hi_level = 4'b0100; irq_ext_hi = 4'b1011; tick(1); irq_ext_hi = 0; tick(4);
      irq_ext_hi = 4'b0100; tick(1); irq_ext_hi = 0; tick(SLOW + 8);
      ext_hi_level = 0;
      enter(0); irq_ext_hi = 4'b1000; tick(1); irq_ext_hi = 0; tick(8);

      // R10: transceiver wake gated by oscillator enable
      cur_req = "R10";
      enter(6);
      trx_wake = 1; tick(1); trx_wake = 0; tick(4);
      trx_osc_en = 1; trx_wake = 1; tick(1); trx_wake = 0; tick(FAST + 8);
      trx_osc_en = 0;

      // R11: wake during start-up absorbed
      cur_req = "R11";
      enter(2); tick(2); pulse_lo(); tick(5); pulse_lo(); tick(3);
      irq_ext_lo = 4'b1111; tick(3); irq_ext_lo = 0; tick(SLOW + 6);

      // R7: reset while asleep, while starting up, and while running
      cur_req = "R7";
      enter(3); tick(3); pulse_rst(); tick(3);
      enter(3); tick(2); pulse_lo(); tick(5); pulse_rst(); tick(3);
      enter(1); pulse_lo(); pulse_rst(); tick(3);
      pulse_rst(); tick(3);

      // R12: peripheral and async-timer interrupts per mode
      cur_req = "R12";
      enter(2);
      irq_sync = 4'b0010; tick(1); irq_sync = 0; tick(3);
      irq_async = 1; tick(1); irq_async = 0; tick(3);
      pulse_rst(); tick(2);
      enter(1); irq_sync = 4'b1000; tick(1); irq_sync = 0; tick(8);
      enter(6); irq_async = 1; tick(1); irq_async = 0; tick(4);
      pulse_rst(); tick(2);
      enter(3); irq_async = 1; tick(1); irq_async = 0; tick(SLOW + 8);

      // R5: minimal hold of four cycles from Idle
      cur_req = "R5";
      enter(0); irq_async = 1; tick(1); irq_async = 0; tick(8);
      enter(4); irq_sync = 4'b0001; tick(1); irq_sync = 0; tick(8);

      finish_up();
   end

endmodule